// File: doc/BRIEF.md
# Auto-Read Fuse Word Controller

This block reads one 32-bit word from a one-time-programmable fuse array in response to a single register write. Software writes a command word that carries two start bits and a word address. The controller then drives the fuse macro through its read sequence without further help. It raises the macro's read-mode controls, pulses the strobe while the word is captured, and returns the macro to standby. The captured word goes into a data-out register, and a completion flag is set in a status register.

The array is 128 bytes, which is 32 words. Words 0 to 23 (the first 96 bytes) form a protected region. Words 24 to 31 are open to any caller. When the `sec_access` input is low, a read of a protected word returns zero and never touches the macro, but it still completes and sets the flag. Software clears the flag by writing a one to it. An interrupt output follows the flag when the build enables it.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset the completion flag is 0 and the data-out register reads 0. `irq` is low. The macro is in standby, meaning `fm_pd`=1 and `fm_csb`=1 with `fm_load`, `fm_pgenb`, `fm_strb_sel`, `fm_rsb` and `fm_strobe` all low.
- R2: A write to offset 0x24 starts a read only when bit 0 (enable) and bit 1 (read) are both 1 in that same write. The word address is taken from bits 25:16, and bits 31:26 are don't-care. A write with only one of the two bits set leaves the macro in standby and the flag at 0.
- R3: A permitted read first holds the macro in read mode for SETUP_CYC cycles, with `fm_csb`=0, `fm_pd`=0 and `fm_load`, `fm_pgenb`, `fm_strb_sel`, `fm_rsb` all 1. It then raises `fm_strobe` for STROBE_CYC cycles while `fm_addr` stays stable, holds read mode with the strobe low for HOLD_CYC cycles, and finally returns to standby. There is exactly one strobe pulse per permitted read.
- R4: The word present on `fm_dout` during the strobe can be read at offset 0x20 once the read finishes. The flag is set SETUP_CYC+STROBE_CYC+HOLD_CYC+1 clock edges after the edge that samples the command (7 with the default parameters).
- R5: Bit 0 of offset 0x18 shows the flag. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. Other offsets read as 0.
- R6: With `sec_access`=0, a read of words 0 to 23 completes one edge after the command, returns 0 and produces no strobe pulse. With `sec_access`=1, the same words read normally.
- R7: A read of a word address of 32 or above returns 0, completes one edge after the command and produces no strobe pulse.
- R8: A command written while a read is in progress is ignored. The data-out register keeps the last completed word until the next read completes.
- R9: `irq` equals the completion flag when IRQ_EN is 1.
- R10: The macro never stays out of standby (`fm_csb`=0) for TIMEOUT_CYC cycles or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the cycle of a read request |
| sec_access | input | 1 | Caller may read the protected region |
| irq | output | 1 | Completion interrupt |
| fm_csb | output | 1 | Macro chip select, active low |
| fm_pd | output | 1 | Macro power-down |
| fm_load | output | 1 | Macro load |
| fm_pgenb | output | 1 | Macro program-enable bar |
| fm_strb_sel | output | 1 | Macro strobe select |
| fm_rsb | output | 1 | Macro read-sense bar |
| fm_strobe | output | 1 | Macro strobe |
| fm_addr | output | 10 | Macro word address |
| fm_dout | input | 32 | Macro word output |

## Verification
The assertions check every cycle that the strobe only rises with the macro in full read mode and that the address stays fixed across a strobe pulse. They also check that standby really idles the macro and that malformed commands never wake it. Further per-cycle checks cover the flag being set by every completion and cleared by a write-one, the data-out register changing only on a completion, and the active window staying under the timeout. Other behaviours only show up in the bench's scenarios: the returned word matching the model's content, the exact completion latency, the masking of protected and out-of-range words, and a second command during a read being dropped.

// File: rtl/fuse_ar_pkg.sv
package fuse_ar_pkg;

    // Register map and command field positions
    localparam int REG_AW       = 8;
    localparam int WORD_W       = 32;
    localparam int WADDR_W      = 10;
    localparam logic [REG_AW-1:0] OFS_STATUS = 8'h18;
    localparam logic [REG_AW-1:0] OFS_DOUT   = 8'h20;
    localparam logic [REG_AW-1:0] OFS_CMD    = 8'h24;
    localparam int CMD_EN_BIT   = 0;
    localparam int CMD_RD_BIT   = 1;
    localparam int CMD_ADDR_LSB = 16;
    localparam int STAT_DONE_BIT = 0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic csb;
        logic pd;
        logic load;
        logic pgenb;
        logic strb_sel;
        logic rsb;
        logic strobe;
    } macro_ctl_t;

    typedef struct packed {
        logic              fire;
        logic [WADDR_W-1:0] waddr;
        logic              allowed;
    } read_cmd_t;

    typedef struct packed {
        logic             valid;
        logic [WORD_W-1:0] data;
    } read_result_t;

    // Macro pin levels for each sequencer state
    function automatic macro_ctl_t ctl_for_state(input seq_state_e s);
        macro_ctl_t c;
        c = '{csb: 1'b1, pd: 1'b1, load: 1'b0, pgenb: 1'b0,
              strb_sel: 1'b0, rsb: 1'b0, strobe: 1'b0};
        if (s == SQ_SETUP || s == SQ_STROBE || s == SQ_HOLD) begin
            c.csb      = 1'b0;
            c.pd       = 1'b0;
            c.load     = 1'b1;
            c.pgenb    = 1'b1;
            c.strb_sel = 1'b1;
            c.rsb      = 1'b1;
            c.strobe   = (s == SQ_STROBE);
        end
        return c;
    endfunction

endpackage

// File: rtl/fuse_ar_gate.sv
module fuse_ar_gate
    import fuse_ar_pkg::*;
#(
    parameter int ARRAY_WORDS  = 32,
    parameter int SECURE_WORDS = 24
) (
    input  logic [WADDR_W-1:0] waddr,
    input  logic               sec_access,
    output logic               allowed
);
    localparam logic [WADDR_W-1:0] ARRAY_LIM  = WADDR_W'(ARRAY_WORDS);
    localparam logic [WADDR_W-1:0] SECURE_LIM = WADDR_W'(SECURE_WORDS);

    logic in_array;
    logic in_secure;

    always_comb begin
        in_array  = (waddr < ARRAY_LIM);
        in_secure = (waddr < SECURE_LIM);
        allowed   = in_array && (sec_access || !in_secure);
    end
endmodule

// File: rtl/fuse_ar_seq.sv
module fuse_ar_seq
    import fuse_ar_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  read_cmd_t          cmd,
    input  logic [WORD_W-1:0]  fm_dout,
    output macro_ctl_t         ctl,
    output logic [WADDR_W-1:0] fm_addr,
    output logic               busy,
    output read_result_t       result
);
    localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);
    localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);

    seq_state_e         st_q;
    logic [CW-1:0]      cnt_q;
    logic [WADDR_W-1:0] addr_q;
    logic [WORD_W-1:0]  cap_q;
    logic               last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            cap_q  <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (cmd.fire) begin
                        addr_q <= cmd.waddr;
                        cap_q  <= '0;
                        if (cmd.allowed) begin
                            st_q  <= SQ_SETUP;
                            cnt_q <= SETUP_LD;
                        end else begin
                            st_q  <= SQ_FINISH;
                        end
                    end
                end
                SQ_SETUP: begin
                    if (last) begin
                        st_q  <= SQ_STROBE;
                        cnt_q <= STROBE_LD;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                SQ_STROBE: begin
                    if (last) begin
                        cap_q <= fm_dout;
                        st_q  <= SQ_HOLD;
                        cnt_q <= HOLD_LD;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                SQ_HOLD: begin
                    if (last) st_q <= SQ_FINISH;
                    else      cnt_q <= cnt_q - CW'(1);
                end
                SQ_FINISH: st_q <= SQ_IDLE;
                default:   st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl          = ctl_for_state(st_q);
        fm_addr      = addr_q;
        busy         = (st_q != SQ_IDLE);
        result.valid = (st_q == SQ_FINISH);
        result.data  = cap_q;
    end
endmodule

// File: rtl/fuse_ar_regs.sv
module fuse_ar_regs
    import fuse_ar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [REG_AW-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic [WORD_W-1:0]  rsp_rdata,
    input  logic               busy,
    input  read_result_t       result,
    output logic               cmd_fire,
    output logic [WADDR_W-1:0] cmd_waddr,
    output logic               flag,
    output logic [WORD_W-1:0]  dout
);
    logic wr_cmd;
    logic wr_stat;
    logic rd_req;
    logic clr;
    logic unused_wbits;

    assign unused_wbits = ^{req_wdata[WORD_W-1:CMD_ADDR_LSB+WADDR_W],
                            req_wdata[CMD_ADDR_LSB-1:CMD_RD_BIT+1]};

    always_comb begin
        wr_cmd    = req_valid && req_write && (req_addr == OFS_CMD);
        wr_stat   = req_valid && req_write && (req_addr == OFS_STATUS);
        rd_req    = req_valid && !req_write;
        clr       = wr_stat && req_wdata[STAT_DONE_BIT];
        cmd_fire  = wr_cmd && req_wdata[CMD_EN_BIT] && req_wdata[CMD_RD_BIT] && !busy;
        cmd_waddr = req_wdata[CMD_ADDR_LSB +: WADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            dout <= '0;
        end else begin
            if (result.valid) begin
                flag <= 1'b1;
                dout <= result.data;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (rd_req) begin
            unique case (req_addr)
                OFS_STATUS: rsp_rdata[STAT_DONE_BIT] = flag;
                OFS_DOUT:   rsp_rdata = dout;
                default:    rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
    import fuse_ar_pkg::*;
#(
    parameter int ARRAY_BYTES  = 128,
    parameter int SECURE_BYTES = 96,
    parameter int SETUP_CYC    = 2,
    parameter int STROBE_CYC   = 3,
    parameter int HOLD_CYC     = 1,
    parameter int TIMEOUT_CYC  = 400,
    parameter bit IRQ_EN       = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [REG_AW-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic [WORD_W-1:0]  rsp_rdata,
    input  logic               sec_access,
    output logic               irq,
    output logic               fm_csb,
    output logic               fm_pd,
    output logic               fm_load,
    output logic               fm_pgenb,
    output logic               fm_strb_sel,
    output logic               fm_rsb,
    output logic               fm_strobe,
    output logic [WADDR_W-1:0] fm_addr,
    input  logic [WORD_W-1:0]  fm_dout
);
    localparam int WORD_BYTES   = WORD_W / 8;
    localparam int ARRAY_WORDS  = ARRAY_BYTES / WORD_BYTES;
    localparam int SECURE_WORDS = SECURE_BYTES / WORD_BYTES;

    read_cmd_t          cmd;
    read_result_t       res_w;
    macro_ctl_t         ctl;
    logic               busy;
    logic               flag_w;
    logic [WORD_W-1:0]  dout_w;
    logic               fire_w;
    logic [WADDR_W-1:0] waddr_w;
    logic               allowed_w;

    fuse_ar_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .busy      (busy),
        .result    (res_w),
        .cmd_fire  (fire_w),
        .cmd_waddr (waddr_w),
        .flag      (flag_w),
        .dout      (dout_w)
    );

    fuse_ar_gate #(
        .ARRAY_WORDS  (ARRAY_WORDS),
        .SECURE_WORDS (SECURE_WORDS)
    ) u_gate (
        .waddr      (waddr_w),
        .sec_access (sec_access),
        .allowed    (allowed_w)
    );

    assign cmd = '{fire: fire_w, waddr: waddr_w, allowed: allowed_w};

    fuse_ar_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .fm_dout (fm_dout),
        .ctl     (ctl),
        .fm_addr (fm_addr),
        .busy    (busy),
        .result  (res_w)
    );

    assign fm_csb      = ctl.csb;
    assign fm_pd       = ctl.pd;
    assign fm_load     = ctl.load;
    assign fm_pgenb    = ctl.pgenb;
    assign fm_strb_sel = ctl.strb_sel;
    assign fm_rsb      = ctl.rsb;
    assign fm_strobe   = ctl.strobe;

    generate
        if (IRQ_EN) begin : g_irq
            assign irq = flag_w;
        end else begin : g_no_irq
            assign irq = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/fuse_ar_chk.sv
module fuse_ar_chk
    import fuse_ar_pkg::*;
#(
    parameter int TIMEOUT_CYC = 400
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [REG_AW-1:0]  req_addr,
    input logic [WORD_W-1:0]  req_wdata,
    input logic               fm_csb,
    input logic               fm_pd,
    input logic               fm_load,
    input logic               fm_pgenb,
    input logic               fm_strb_sel,
    input logic               fm_rsb,
    input logic               fm_strobe,
    input logic [WADDR_W-1:0] fm_addr,
    input logic               done,
    input logic               flag,
    input logic [WORD_W-1:0]  dout
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] active_cnt;
    logic          clr_wr;
    logic          bad_cmd_wr;

    assign clr_wr = req_valid && req_write && (req_addr == OFS_STATUS) && req_wdata[STAT_DONE_BIT];
    assign bad_cmd_wr = req_valid && req_write && (req_addr == OFS_CMD) &&
                        !(req_wdata[CMD_EN_BIT] && req_wdata[CMD_RD_BIT]);

    always_ff @(posedge clk) begin
        if (rst || fm_csb) active_cnt <= '0;
        else if (active_cnt != TW'(TIMEOUT_CYC)) active_cnt <= active_cnt + TW'(1);
    end

    // R3
    strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        fm_strobe |-> (!fm_csb && !fm_pd && fm_load && fm_pgenb && fm_strb_sel && fm_rsb));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_strobe && $past(fm_strobe)) |-> $stable(fm_addr));

    // R1
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        fm_pd |-> (fm_csb && !fm_strobe && !fm_load));

    // R2
    bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_cmd_wr && fm_csb) |=> fm_csb);

    // R4
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> flag);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !done) |=> !flag);

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(dout));

    // R10
    active_window_chk: assert property (@(posedge clk) disable iff (rst)
        active_cnt < TW'(TIMEOUT_CYC));
endmodule

bind fuse_autoread_ctrl fuse_ar_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .fm_csb      (fm_csb),
    .fm_pd       (fm_pd),
    .fm_load     (fm_load),
    .fm_pgenb    (fm_pgenb),
    .fm_strb_sel (fm_strb_sel),
    .fm_rsb      (fm_rsb),
    .fm_strobe   (fm_strobe),
    .fm_addr     (fm_addr),
    .done        (res_w.valid),
    .flag        (flag_w),
    .dout        (dout_w)
);

// File: tb/fuse_autoread_ctrl_test.sv
module fuse_autoread_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FULL_LAT   = 2 + 3 + 1 + 1;
    localparam int SHORT_LAT  = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        sec_access = 1'b0;
    logic        irq;
    logic        fm_csb, fm_pd, fm_load, fm_pgenb, fm_strb_sel, fm_rsb, fm_strobe;
    logic [9:0]  fm_addr;
    logic [31:0] fm_dout;

    int n_tests = 0;
    int n_fail  = 0;
    int strobe_cnt = 0;

    logic [31:0] exp_q[$];
    string       exp_tag_q[$];
    logic [31:0] act_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_autoread_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .sec_access(sec_access), .irq(irq), .fm_csb(fm_csb), .fm_pd(fm_pd),
        .fm_load(fm_load), .fm_pgenb(fm_pgenb), .fm_strb_sel(fm_strb_sel),
        .fm_rsb(fm_rsb), .fm_strobe(fm_strobe), .fm_addr(fm_addr), .fm_dout(fm_dout)
    );

    // Behavioural fuse macro: word content derived from its address
    function automatic logic [31:0] fuse_word(input logic [9:0] w);
        return {w[7:0] ^ 8'hC3, ~w[7:0], w[7:0] + 8'h11, 8'h3C};
    endfunction

    assign fm_dout = (!fm_csb && fm_load && fm_rsb && fm_strobe) ? fuse_word(fm_addr) : 32'h0;

    always @(posedge fm_strobe) strobe_cnt = strobe_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    // Scoreboard monitor: pairs expected and observed words in order
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                logic [31:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = exp_tag_q.pop_front();
                a = act_q.pop_front();
                check(a === e, t, a, e);
            end
        end
    end

    // Issue one read, measure latency and strobes, collect result, clear flag
    task automatic do_read(input logic [31:0] cmd_word, input bit sec, input int exp_lat,
                           input int exp_strobes, input logic [31:0] exp_data, input string tag);
        int lat;
        int s0;
        logic [31:0] rd;
        sec_access = sec;
        s0 = strobe_cnt;
        exp_q.push_back(exp_data);
        exp_tag_q.push_back({tag, " data"});
        bus_write(8'h24, cmd_word);
        lat = 0;
        while (!irq && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
        check(strobe_cnt - s0 == exp_strobes, {tag, " strobes R3"}, 32'(strobe_cnt - s0), 32'(exp_strobes));
        check(irq === 1'b1, {tag, " irq R9"}, {31'b0, irq}, 32'd1);
        bus_read(8'h18, rd);
        check(rd === 32'h1, {tag, " status R5"}, rd, 32'h1);
        bus_read(8'h20, rd);
        act_q.push_back(rd);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, rd);
        check(rd === 32'h0, {tag, " w1c R5"}, rd, 32'h0);
        check(irq === 1'b0, {tag, " irq low R9"}, {31'b0, irq}, 32'd0);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [9:0] w);
        return 32'h3 | (32'(w) << 16);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h18, rd); check(rd === 32'h0, "R1 status", rd, 32'h0);
        bus_read(8'h20, rd); check(rd === 32'h0, "R1 dout", rd, 32'h0);
        check(fm_pd && fm_csb && !fm_strobe && !fm_load && !fm_pgenb && !fm_strb_sel && !fm_rsb,
              "R1 standby", {25'b0, fm_csb, fm_pd, fm_load, fm_pgenb, fm_strb_sel, fm_rsb, fm_strobe},
              {25'b0, 7'b1100000});
        check(irq === 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4 open region reads
        do_read(mk_cmd(10'd24), 1'b0, FULL_LAT, 1, fuse_word(10'd24), "R4 word24");
        do_read(mk_cmd(10'd31), 1'b0, FULL_LAT, 1, fuse_word(10'd31), "R4 word31");
        do_read(32'hFC00_0003 | (32'd26 << 16), 1'b0, FULL_LAT, 1, fuse_word(10'd26), "R2 upper bits");

        // R6 protected region
        do_read(mk_cmd(10'd5), 1'b1, FULL_LAT, 1, fuse_word(10'd5), "R6 allowed word5");
        do_read(mk_cmd(10'd0), 1'b0, SHORT_LAT, 0, 32'h0, "R6 blocked word0");
        do_read(mk_cmd(10'd23), 1'b0, SHORT_LAT, 0, 32'h0, "R6 blocked word23");

        // R7 beyond the array
        do_read(mk_cmd(10'd32), 1'b1, SHORT_LAT, 0, 32'h0, "R7 word32");
        do_read(mk_cmd(10'd1023), 1'b1, SHORT_LAT, 0, 32'h0, "R7 word1023");

        // R2 single start bit ignored
        s0 = strobe_cnt;
        bus_write(8'h24, 32'h1 | (32'd25 << 16));
        bus_write(8'h24, 32'h2 | (32'd25 << 16));
        repeat (20) @(negedge clk);
        bus_read(8'h18, rd); check(rd === 32'h0, "R2 partial cmd status", rd, 32'h0);
        check(strobe_cnt == s0, "R2 partial cmd strobes", 32'(strobe_cnt), 32'(s0));

        // R5 writing zero to status leaves flag set
        sec_access = 1'b0;
        bus_write(8'h24, mk_cmd(10'd28));
        repeat (10) @(negedge clk);
        bus_write(8'h18, 32'h0);
        bus_read(8'h18, rd); check(rd === 32'h1, "R5 write zero keeps flag", rd, 32'h1);
        bus_read(8'h20, rd); check(rd === fuse_word(10'd28), "R4 word28", rd, fuse_word(10'd28));
        bus_read(8'h30, rd); check(rd === 32'h0, "R5 other offset", rd, 32'h0);
        bus_write(8'h18, 32'h1);

        // R8 command during a read is dropped
        s0 = strobe_cnt;
        bus_write(8'h24, mk_cmd(10'd30));
        bus_write(8'h24, mk_cmd(10'd25));
        repeat (12) @(negedge clk);
        bus_read(8'h20, rd); check(rd === fuse_word(10'd30), "R8 first read wins", rd, fuse_word(10'd30));
        check(strobe_cnt - s0 == 1, "R8 single strobe", 32'(strobe_cnt - s0), 32'd1);
        bus_write(8'h18, 32'h1);
        repeat (20) @(negedge clk);
        bus_read(8'h18, rd); check(rd === 32'h0, "R8 no second completion", rd, 32'h0);
        bus_read(8'h20, rd); check(rd === fuse_word(10'd30), "R8 dout holds", rd, fuse_word(10'd30));

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule